// File: doc/BRIEF.md
# Correlator-Bank Phase Symbol Detector

This block decides phase-modulated symbols straight from real passband samples taken at a fixed ten samples per carrier cycle. It needs no I/Q split, no interpolation and no internal rate above the input rate. Each accepted sample enters a short tap history. Sixteen four-tap correlators read that history, one correlator for each candidate carrier phase. Each correlator's output is summed over the current symbol.

An external timing source marks the first sample of each symbol with a strobe. On that strobe the block closes the finished symbol. It reports the index of the correlator with the largest signed sum, together with that sum, and restarts all sums from the strobe cycle's sample. A mode input picks one of two coefficient sets. The coarse set places the candidate phases 8 degrees apart, so sixteen points cover a 120-degree arc. The fine set places them 4 degrees apart. Both sets are built as constants when the design is elaborated.

Top module: `psk_corr_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sym_valid`, `sym_index` and `sym_metric` are all zero. Reset also clears the tap history and every correlator sum.
- R2: With `fine_mode` low, correlator p at each accepted sample produces y_p = sum over k=0..3 of c_p[k]*x[n-k], where x[n] is the current sample (k=0 is the newest). The coefficient is c_p[k] = round(2047*cos(2*pi*k/10 + p*8 degrees)).
- R3: With `fine_mode` high, the same sum uses c_p[k] = round(2047*cos(2*pi*k/10 + p*4 degrees)). The mode may change between symbols.
- R4: A sample accepted in a cycle where `sym_edge` is high is the first sample of the new symbol. Every sum restarts from that sample's contribution, or from zero when no sample is accepted in that cycle. A symbol may contain a single sample.
- R5: `sym_valid` is high for exactly one cycle, the cycle after each cycle in which `sym_edge` is high, and is low otherwise.
- R6: `sym_index` gives the correlator whose signed sum over the closed symbol is largest, and `sym_metric` gives that sum as a two's-complement value.
- R7: When several sums share the maximum, the lowest correlator index is reported.
- R8: A cycle with `in_valid` low changes neither the tap history nor any sum, whatever `in_sample` holds.
- R9: Sums do not wrap for symbols of up to 64 accepted samples at any input values, including full-scale negative.
- R10: `sym_index` and `sym_metric` hold their last decision in every cycle where `sym_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_sample` as an accepted sample |
| in_sample | input | 12 | Signed passband sample |
| sym_edge | input | 1 | First cycle of a new symbol; closes the previous one |
| fine_mode | input | 1 | 0: 8-degree phase steps, 1: 4-degree phase steps |
| sym_valid | output | 1 | One-cycle decision strobe |
| sym_index | output | 4 | Winning correlator index |
| sym_metric | output | 32 | Signed winning per-symbol sum |

## Verification
The sums change at the clock edge that samples an accepted input. The decision for a symbol is registered at the edge that samples `sym_edge`, so `sym_valid`, `sym_index` and `sym_metric` show the new decision in the cycle right after the strobe cycle. The bench drives inputs on the falling edge and a cycle model updates its sums and history at the rising edge. The bench captures the expected argmax from the model's sums before that edge and compares them with the outputs one time unit after it. Every cycle also checks that `sym_valid` equals the strobe of the cycle before and, when low, that the index and metric match the previous decision.

// File: rtl/psk_corr_pkg.sv
package psk_corr_pkg;

    localparam real PSK_PI = 3.14159265358979323846;

    // Rounded, scaled cosine for one tap of one phase lane.
    function automatic int coef_value(
        input int scale,
        input int base_deg,
        input int step_deg,
        input int lane,
        input int tap,
        input int per_cycle
    );
        real ang;
        ang = 2.0 * PSK_PI * real'(tap) / real'(per_cycle)
            + real'(base_deg + lane * step_deg) * PSK_PI / 180.0;
        return int'(real'(scale) * $cos(ang));
    endfunction

    function automatic int acc_width(
        input int sample_w,
        input int coef_w,
        input int taps,
        input int max_len
    );
        return sample_w + coef_w + $clog2(taps) + $clog2(max_len);
    endfunction

endpackage

// File: rtl/psk_tap_line.sv
module psk_tap_line #(
    parameter int SAMPLE_W = 12,
    parameter int TAPS     = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic [SAMPLE_W-1:0]                in_sample,
    output logic [TAPS-1:0][SAMPLE_W-1:0]      window
);
    localparam int HIST = TAPS - 1;

    typedef struct packed {
        logic [HIST-1:0][SAMPLE_W-1:0] hist;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (in_valid) begin
            line_d.hist[0] = in_sample;
            for (int i = 1; i < HIST; i++) begin
                line_d.hist[i] = line_q.hist[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    always_comb begin
        window[0] = in_sample;
        for (int k = 1; k < TAPS; k++) begin
            window[k] = line_q.hist[k-1];
        end
    end

    // R8: an idle cycle leaves the history untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(line_q.hist));

endmodule

// File: rtl/psk_corr_bank.sv
module psk_corr_bank
    import psk_corr_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int COEF_W      = 12,
    parameter int TAPS        = 4,
    parameter int NUM_PH      = 16,
    parameter int PER_CYCLE   = 10,
    parameter int BASE_DEG    = 0,
    parameter int COARSE_STEP = 8,
    parameter int FINE_STEP   = 4,
    parameter int ACC_W       = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic                               sym_edge,
    input  logic                               fine_mode,
    input  logic [TAPS-1:0][SAMPLE_W-1:0]      window,
    output logic [NUM_PH-1:0][ACC_W-1:0]       sums
);
    localparam int SCALE = (1 << (COEF_W - 1)) - 1;

    logic [NUM_PH-1:0][TAPS-1:0][COEF_W-1:0] coef;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_lane
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            localparam int CF_COARSE =
                coef_value(SCALE, BASE_DEG, COARSE_STEP, p, k, PER_CYCLE);
            localparam int CF_FINE =
                coef_value(SCALE, BASE_DEG, FINE_STEP, p, k, PER_CYCLE);
            localparam logic [COEF_W-1:0] C_COARSE = COEF_W'(CF_COARSE);
            localparam logic [COEF_W-1:0] C_FINE   = COEF_W'(CF_FINE);
            assign coef[p][k] = fine_mode ? C_FINE : C_COARSE;
        end
    end

    typedef struct packed {
        logic [NUM_PH-1:0][ACC_W-1:0] acc;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_PH-1:0][ACC_W-1:0] lane_out;

    always_comb begin
        for (int p = 0; p < NUM_PH; p++) begin
            logic signed [ACC_W-1:0] total;
            total = '0;
            for (int k = 0; k < TAPS; k++) begin
                logic signed [ACC_W-1:0] xs;
                logic signed [ACC_W-1:0] cs;
                xs = ACC_W'($signed(window[k]));
                cs = ACC_W'($signed(coef[p][k]));
                total = total + xs * cs;
            end
            lane_out[p] = total;
        end
    end

    always_comb begin
        bank_d = bank_q;
        for (int p = 0; p < NUM_PH; p++) begin
            if (sym_edge) begin
                bank_d.acc[p] = in_valid ? lane_out[p] : '0;
            end else if (in_valid) begin
                bank_d.acc[p] = bank_q.acc[p] + lane_out[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sums = bank_q.acc;

    // R4: a strobe with no sample restarts every sum at zero
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (sym_edge && !in_valid) |=> (bank_q.acc == '0));

    // R8: without a sample and without a strobe, sums hold
    assert_idle_sums_R8: assert property (@(posedge clk) disable iff (rst)
        (!sym_edge && !in_valid) |=> $stable(bank_q.acc));

endmodule

// File: rtl/psk_argmax.sv
module psk_argmax #(
    parameter int NUM_PH = 16,
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 4
) (
    input  logic [NUM_PH-1:0][ACC_W-1:0] sums,
    output logic [IDX_W-1:0]             best_idx,
    output logic [ACC_W-1:0]             best_val
);
    always_comb begin
        best_idx = '0;
        best_val = sums[0];
        for (int i = 1; i < NUM_PH; i++) begin
            if ($signed(sums[i]) > $signed(best_val)) begin
                best_idx = IDX_W'(i);
                best_val = sums[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PH; i++) begin
            // R6: no lane beats the reported value
            assert_is_max_R6: assert ($signed(sums[i]) <= $signed(best_val));
            // R7: every lane below the winner is strictly smaller
            if (IDX_W'(i) < best_idx) begin
                assert_tie_low_R7: assert ($signed(sums[i]) < $signed(best_val));
            end
        end
    end

endmodule

// File: rtl/psk_corr_detector.sv
module psk_corr_detector
    import psk_corr_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int COEF_W      = 12,
    parameter int TAPS        = 4,
    parameter int NUM_PH      = 16,
    parameter int PER_CYCLE   = 10,
    parameter int BASE_DEG    = 0,
    parameter int COARSE_STEP = 8,
    parameter int FINE_STEP   = 4,
    parameter int MAX_SYM_LEN = 64,
    localparam int IDX_W      = $clog2(NUM_PH),
    localparam int ACC_W      = acc_width(SAMPLE_W, COEF_W, TAPS, MAX_SYM_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_sample,
    input  logic                 sym_edge,
    input  logic                 fine_mode,
    output logic                 sym_valid,
    output logic [IDX_W-1:0]     sym_index,
    output logic [ACC_W-1:0]     sym_metric
);
    logic [TAPS-1:0][SAMPLE_W-1:0] window;
    logic [NUM_PH-1:0][ACC_W-1:0]  sums;
    logic [IDX_W-1:0]              win_idx;
    logic [ACC_W-1:0]              win_val;

    psk_tap_line #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (TAPS)
    ) u_line (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .window    (window)
    );

    psk_corr_bank #(
        .SAMPLE_W    (SAMPLE_W),
        .COEF_W      (COEF_W),
        .TAPS        (TAPS),
        .NUM_PH      (NUM_PH),
        .PER_CYCLE   (PER_CYCLE),
        .BASE_DEG    (BASE_DEG),
        .COARSE_STEP (COARSE_STEP),
        .FINE_STEP   (FINE_STEP),
        .ACC_W       (ACC_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sym_edge  (sym_edge),
        .fine_mode (fine_mode),
        .window    (window),
        .sums      (sums)
    );

    psk_argmax #(
        .NUM_PH (NUM_PH),
        .ACC_W  (ACC_W),
        .IDX_W  (IDX_W)
    ) u_max (
        .sums     (sums),
        .best_idx (win_idx),
        .best_val (win_val)
    );

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] metric;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = sym_edge;
        if (sym_edge) begin
            dec_d.idx    = win_idx;
            dec_d.metric = win_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign sym_valid  = dec_q.valid;
    assign sym_index  = dec_q.idx;
    assign sym_metric = dec_q.metric;

    // Samples accepted in the open symbol, used only by the length check.
    localparam int CNT_W = $clog2(MAX_SYM_LEN + 1) + 2;
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
        end else if (sym_edge) begin
            len_q <= in_valid ? CNT_W'(1) : '0;
        end else if (in_valid && len_q <= CNT_W'(MAX_SYM_LEN)) begin
            len_q <= len_q + CNT_W'(1);
        end
    end

    // R9: sums are sized for symbols no longer than the configured limit
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        len_q <= CNT_W'(MAX_SYM_LEN));

    // R5: a strobe is always followed by exactly one decision strobe
    assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (rst)
        sym_edge |=> sym_valid);

    assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !$past(rst)) |-> $past(sym_edge));

    // R10: decision fields hold between strobes
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!sym_valid && !$past(rst)) |-> ($stable(sym_index) && $stable(sym_metric)));

endmodule

// File: tb/sim_psk_corr_detector.sv
module sim_psk_corr_detector;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PH     = 16;
    localparam int TAPS       = 4;
    localparam real PI        = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [11:0] in_sample;
    logic        sym_edge;
    logic        fine_mode;
    logic        sym_valid;
    logic [3:0]  sym_index;
    logic [31:0] sym_metric;

    always #(CLK_PERIOD/2) clk = ~clk;

    psk_corr_detector u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .sym_edge   (sym_edge),
        .fine_mode  (fine_mode),
        .sym_valid  (sym_valid),
        .sym_index  (sym_index),
        .sym_metric (sym_metric)
    );

    int     checks = 0;
    int     errors = 0;
    longint acc_m [NUM_PH];
    int     hist_m [TAPS-1];
    int     last_idx = 0;
    longint last_val = 0;

    function automatic int cf(input int p, input int k, input logic fm);
        real ang;
        ang = 2.0 * PI * real'(k) / 10.0 + real'(p * (fm ? 4 : 8)) * PI / 180.0;
        return int'(2047.0 * $cos(ang));
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_model();
        for (int p = 0; p < NUM_PH; p++) acc_m[p] = 0;
        for (int i = 0; i < TAPS-1; i++) hist_m[i] = 0;
        last_idx = 0;
        last_val = 0;
    endtask

    // One clock: drive on the falling edge, update the model at the rising
    // edge, compare one time unit after it.
    task automatic step(input logic v, input int s, input logic e,
                        input logic fm, input string req);
        int     exp_idx;
        longint exp_val;
        @(negedge clk);
        in_valid  = v;
        in_sample = 12'(s);
        sym_edge  = e;
        fine_mode = fm;
        exp_idx = 0;
        exp_val = acc_m[0];
        for (int p = 1; p < NUM_PH; p++) begin
            if (acc_m[p] > exp_val) begin
                exp_idx = p;
                exp_val = acc_m[p];
            end
        end
        @(posedge clk);
        for (int p = 0; p < NUM_PH; p++) begin
            longint y;
            y = longint'(cf(p, 0, fm)) * s;
            for (int k = 1; k < TAPS; k++) y += longint'(cf(p, k, fm)) * hist_m[k-1];
            if (e) acc_m[p] = v ? y : 0;
            else if (v) acc_m[p] += y;
        end
        if (v) begin
            for (int i = TAPS-2; i > 0; i--) hist_m[i] = hist_m[i-1];
            hist_m[0] = s;
        end
        #1;
        check("R5 valid strobe", longint'(sym_valid), longint'(e));
        if (e) begin
            check({req, " index"}, longint'(sym_index), longint'(exp_idx));
            check({req, " metric"}, longint'($signed(sym_metric)), exp_val);
            last_idx = exp_idx;
            last_val = exp_val;
        end else begin
            check("R10 index hold", longint'(sym_index), longint'(last_idx));
            check("R10 metric hold", longint'($signed(sym_metric)), last_val);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 12'h5A5;
        sym_edge = 1'b1;
        fine_mode = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset valid", longint'(sym_valid), 0);
        check("R1 reset index", longint'(sym_index), 0);
        check("R1 reset metric", longint'(sym_metric), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        sym_edge = 1'b0;
        @(posedge clk);
        #1;
        check("R1 first cycle valid", longint'(sym_valid), 0);
        check("R1 first cycle metric", longint'(sym_metric), 0);
        clear_model();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        sym_edge = 1'b0;
        fine_mode = 1'b0;
        do_reset();

        // R8: junk with valid low, then close the symbol: all sums zero,
        // tie at zero goes to lane 0 (R7)
        for (int i = 0; i < 12; i++) step(1'b0, 1000 - 170 * i, 1'b0, 1'b0, "R8");
        step(1'b0, 777, 1'b1, 1'b0, "R8 R7 idle tie");

        // Phase sweep in both modes, symbol lengths 20..35, idle gaps
        for (int fm = 0; fm < 2; fm++) begin
            for (int p = 0; p < NUM_PH; p++) begin
                int len;
                int n;
                real phi;
                len = 20 + p;
                phi = -real'(p * (fm ? 4 : 8)) * PI / 180.0;
                n = 0;
                while (n < len) begin
                    int s;
                    s = int'(1500.0 * $cos(2.0 * PI * real'(n) / 10.0 + phi));
                    if ((n % 7) == 3) step(1'b0, -s, 1'b0, 1'(fm), "R8 gap");
                    step(1'b1, s, (n == 0), 1'(fm), fm ? "R3 R6" : "R2 R6");
                    n++;
                end
            end
        end
        step(1'b0, 0, 1'b1, 1'b1, "R3 R4 close");

        // R7: a symbol of zero samples ties all lanes
        for (int i = 0; i < 20; i++) step(1'b1, 0, (i == 0), 1'b0, "R7");
        step(1'b1, 321, 1'b1, 1'b0, "R7 zero tie");

        // R4: one-sample symbols back to back
        step(1'b1, -900, 1'b1, 1'b0, "R4 single");
        step(1'b1, 1200, 1'b1, 1'b1, "R4 single");
        step(1'b0, 0, 1'b1, 1'b0, "R4 single");

        // R9: full-scale 64-sample symbols, negative then alternating
        for (int i = 0; i < 64; i++) step(1'b1, -2048, (i == 0), 1'b0, "R9");
        for (int i = 0; i < 64; i++)
            step(1'b1, ((i % 10) < 5) ? 2047 : -2048, (i == 0), 1'b0, "R9 full scale");
        step(1'b0, 0, 1'b1, 1'b0, "R9 full scale");

        // R1: reset mid-symbol clears history and sums
        for (int i = 0; i < 5; i++) step(1'b1, 1800, (i == 0), 1'b1, "R1 pre");
        do_reset();
        step(1'b1, 1000, 1'b0, 1'b0, "R1");
        step(1'b0, 0, 1'b1, 1'b0, "R1 cleared history");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule